// File: doc/BRIEF.md
# I2C Master SCL Phase Timer

This block produces the SCL clock of an I2C master from a fast reference clock. Each SCL period has a low phase and a high phase. Their lengths are chosen by a two-bit ratio code, which picks a pair of low and high unit counts, and by a divider value, which sets how many reference cycles make up one unit. A fixed overhead of reference cycles is added to every high phase. It stands for rise time and for the delay of the input synchronizer.

The block drives a single open-drain control, `scl_drive_low`, and reads back the synchronized state of the SCL wire. The high-phase count only advances while the wire is actually high. A device that holds SCL low therefore stretches the period. In slave mode a divider of zero is raised to one. A one-cycle `edge_tick` marks the first cycle of every phase, so that the surrounding bit engine can place its data changes. The ratio code, the divider value and the mode bit are captured only when a low phase starts. When the block is disabled it releases the line and clears its counters.

Top module: `scl_phase_timer`

## Requirements
- R1: Ratio code 0 gives a low phase of 4*(D+1) reference cycles and a high phase of 4*(D+1)+8 cycles. D is the effective divider.
- R2: Ratio code 1 gives a low phase of 6*(D+1) cycles and a high phase of 3*(D+1)+8 cycles.
- R3: Ratio code 2 gives a low phase of 11*(D+1) cycles and a high phase of 6*(D+1)+8 cycles.
- R4: Ratio code 3 gives the same timing as code 0.
- R5: An unstretched period lasts (Nlow+Nhigh)*(D+1)+8 reference cycles. With a divider of 0 in master mode, one unit is a single cycle.
- R6: When `slave_mode` is 1, a divider value of 0 is used as 1. Nonzero values are used unchanged.
- R7: High-phase cycles are counted only while `scl_sense` is 1. The block never starts driving low in the cycle after one in which it was released and sensed the line low. After enable, the first low phase waits until the line is sensed high.
- R8: When `en` is 0, `scl_drive_low` is 0 from the next cycle on and `edge_tick` stays 0. After re-enable, the block starts with a full low phase.
- R9: The ratio code, divider and mode bit are captured at the start of each low phase. A change made during a period affects only the next period.
- R10: `edge_tick` is 1 for exactly one cycle, the first cycle of each low phase and the first released cycle of each high phase, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Enables SCL generation |
| ratio_sel | input | 2 | Low/high ratio code (0 standard, 1 asymmetric, 2 fast, 3 same as 0) |
| div_val | input | DIV_W (9) | Divider; one unit lasts div_val+1 cycles |
| slave_mode | input | 1 | 1 raises a divider of 0 to 1 |
| scl_sense | input | 1 | Synchronized level of the SCL wire |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| edge_tick | output | 1 | One-cycle pulse in the first cycle of each phase |

## Verification
Any fault in the phase counter or in the captured lengths shows up in the very next period. The low-phase or high-phase run length at `scl_drive_low` comes out wrong by the number of miscounted cycles, so the bench measures both phase lengths directly at the port for every ratio, divider and mode pair. A stuck phase bit or a missed capture makes the line freeze, or carry over the old timing, within one period. A wrong tick shows up in the same cycle as a tick that is missing or misplaced relative to a line edge.

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int DIV_W    = 9,
  parameter int OVERHEAD = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       ratio_sel,
  input  logic [DIV_W-1:0] div_val,
  input  logic             slave_mode,
  input  logic             scl_sense,
  output logic             scl_drive_low,
  output logic             edge_tick
);
  localparam int N_W   = 4;
  localparam int CNT_W = $clog2(16 * (1 << DIV_W) + OVERHEAD + 1);

  logic [N_W-1:0]   n_lo, n_hi;
  logic [DIV_W-1:0] div_eff;
  logic [CNT_W-1:0] unit_len, lo_next, hi_next;
  logic [CNT_W-1:0] cnt, lo_len, hi_len;
  logic             active, start_lo;

  always_comb begin
    case (ratio_sel)
      2'd1:    begin n_lo = N_W'(6);  n_hi = N_W'(3); end
      2'd2:    begin n_lo = N_W'(11); n_hi = N_W'(6); end
      default: begin n_lo = N_W'(4);  n_hi = N_W'(4); end
    endcase
  end

  assign div_eff  = (slave_mode && div_val == '0) ? DIV_W'(1) : div_val;
  assign unit_len = CNT_W'(div_eff) + CNT_W'(1);
  assign lo_next  = CNT_W'(n_lo) * unit_len;
  assign hi_next  = CNT_W'(n_hi) * unit_len + CNT_W'(OVERHEAD);

  assign start_lo = scl_sense && (!active || (cnt + CNT_W'(1) == hi_len));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      active        <= 1'b0;
      scl_drive_low <= 1'b0;
      edge_tick     <= 1'b0;
      cnt           <= '0;
      lo_len        <= '0;
      hi_len        <= '0;
    end else begin
      edge_tick <= 1'b0;
      if (!active || !scl_drive_low) begin
        if (start_lo) begin
          active        <= 1'b1;
          scl_drive_low <= 1'b1;
          edge_tick     <= 1'b1;
          cnt           <= CNT_W'(1);
          lo_len        <= lo_next;
          hi_len        <= hi_next;
        end else if (scl_sense) begin
          cnt <= cnt + CNT_W'(1);
        end
      end else if (cnt == lo_len) begin
        scl_drive_low <= 1'b0;
        edge_tick     <= 1'b1;
        cnt           <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/scl_phase_timer_chk.sv
module scl_phase_timer_chk #(
  parameter int DIV_W = 9
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl_sense,
  input logic scl_drive_low,
  input logic edge_tick
);
  localparam int RUN_W = $clog2(16 * (1 << DIV_W) + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic [RUN_W-1:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n)             low_run <= '0;
    else if (!scl_drive_low) low_run <= '0;
    else if (low_run != RUN_MAX) low_run <= low_run + RUN_W'(1);
  end

  p_off_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !scl_drive_low);

  p_stretch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en && !scl_drive_low && !scl_sense |=> !scl_drive_low);

  p_tick_on_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    edge_tick |-> scl_drive_low != $past(scl_drive_low));

  p_edge_gets_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) && (scl_drive_low != $past(scl_drive_low)) |-> edge_tick);

  p_tick_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    edge_tick |=> !edge_tick);

  p_low_min_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) && $fell(scl_drive_low) |-> low_run >= RUN_W'(4));
endmodule

bind scl_phase_timer scl_phase_timer_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .scl_sense(scl_sense),
  .scl_drive_low(scl_drive_low), .edge_tick(edge_tick)
);

// File: tb/tb_scl_phase_timer.sv
`timescale 1ns/1ps
module tb_scl_phase_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] ratio_sel = 2'd0;
  logic [8:0] div_val = 9'd0;
  logic       slave_mode = 1'b0;
  logic       hold = 1'b0;
  logic       scl_sense;
  logic       scl_drive_low, edge_tick;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;
  assign scl_sense = ~scl_drive_low & ~hold;

  scl_phase_timer dut (
    .clk(clk), .rst_n(rst_n), .en(en), .ratio_sel(ratio_sel), .div_val(div_val),
    .slave_mode(slave_mode), .scl_sense(scl_sense),
    .scl_drive_low(scl_drive_low), .edge_tick(edge_tick)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sync_low();
    do @(negedge clk); while (!(scl_drive_low && edge_tick));
  endtask

  task automatic run_period(output int lo, output int hi, output int bad);
    lo = 0; hi = 0; bad = 0;
    while (scl_drive_low) begin
      if (edge_tick != (lo == 0)) bad++;
      lo++; @(negedge clk);
    end
    while (!scl_drive_low) begin
      if (edge_tick != (hi == 0)) bad++;
      hi++; @(negedge clk);
    end
  endtask

  task automatic t_timing(string req, logic [1:0] r, int d, logic s, int elo, int ehi);
    int lo, hi, bad;
    @(negedge clk); en = 1'b0;
    @(negedge clk); ratio_sel = r; div_val = 9'(d); slave_mode = s; en = 1'b1;
    sync_low();
    run_period(lo, hi, bad);
    chk({req, " low"}, lo, elo);
    chk({req, " high"}, hi, ehi);
    chk({req, " R10 tick"}, bad, 0);
  endtask

  task automatic t_period_r5();
    int lo, hi, bad;
    @(negedge clk); en = 1'b0;
    @(negedge clk); ratio_sel = 2'd2; div_val = 9'd3; slave_mode = 1'b0; en = 1'b1;
    sync_low();
    run_period(lo, hi, bad);
    chk("R5 period", lo + hi, 17 * 4 + 8);
  endtask

  task automatic t_stretch_r7();
    int lo, hi;
    @(negedge clk); en = 1'b0;
    @(negedge clk); ratio_sel = 2'd0; div_val = 9'd0; slave_mode = 1'b0;
    hold = 1'b1; en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R7 wait before first low", int'(scl_drive_low), 0);
    end
    hold = 1'b0;
    sync_low();
    hold = 1'b1;
    lo = 0;
    while (scl_drive_low) begin lo++; @(negedge clk); end
    chk("R7 low", lo, 4);
    hi = 0;
    for (int i = 0; i < 5; i++) begin
      chk("R7 stays released", int'(scl_drive_low), 0);
      hi++; @(negedge clk);
    end
    hold = 1'b0;
    while (!scl_drive_low) begin hi++; @(negedge clk); end
    chk("R7 stretched high", hi, 5 + 12);
  endtask

  task automatic t_disable_r8();
    int lo, hi, bad;
    @(negedge clk); en = 1'b0;
    @(negedge clk); ratio_sel = 2'd0; div_val = 9'd0; slave_mode = 1'b0; en = 1'b1;
    sync_low();
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk("R8 release in low", int'(scl_drive_low), 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R8 no tick when off", int'(edge_tick) + int'(scl_drive_low), 0);
    end
    en = 1'b1;
    sync_low();
    run_period(lo, hi, bad);
    chk("R8 full low after re-enable", lo, 4);
    chk("R8 high after re-enable", hi, 12);
    sync_low();
    repeat (6) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R8 release in high", int'(scl_drive_low), 0);
  endtask

  task automatic t_change_r9();
    int lo, hi, bad;
    @(negedge clk); en = 1'b0;
    @(negedge clk); ratio_sel = 2'd0; div_val = 9'd1; slave_mode = 1'b0; en = 1'b1;
    sync_low();
    @(negedge clk); ratio_sel = 2'd2; div_val = 9'd0;
    lo = 1;
    while (scl_drive_low) begin lo++; @(negedge clk); end
    hi = 0;
    while (!scl_drive_low) begin hi++; @(negedge clk); end
    chk("R9 current low kept", lo, 8);
    chk("R9 current high kept", hi, 16);
    run_period(lo, hi, bad);
    chk("R9 next low new", lo, 11);
    chk("R9 next high new", hi, 14);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R8 reset drive", int'(scl_drive_low), 0);
    chk("R10 reset tick", int'(edge_tick), 0);
    rst_n = 1'b1;
    t_timing("R1 d1", 2'd0, 1, 1'b0, 8, 16);
    t_timing("R1 d0", 2'd0, 0, 1'b0, 4, 12);
    t_timing("R2 d2", 2'd1, 2, 1'b0, 18, 17);
    t_timing("R3 d0", 2'd2, 0, 1'b0, 11, 14);
    t_timing("R4 d1", 2'd3, 1, 1'b0, 8, 16);
    t_period_r5();
    t_timing("R6 slave d0 r0", 2'd0, 0, 1'b1, 8, 16);
    t_timing("R6 slave d0 r1", 2'd1, 0, 1'b1, 12, 14);
    t_timing("R6 slave d2", 2'd0, 2, 1'b1, 12, 20);
    t_stretch_r7();
    t_disable_r8();
    t_change_r9();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule